// File: doc/BRIEF.md
# Address-Dependent Wait-State Clock Divider

This block paces a small processor's bus cycles against a base clock enable that runs at one twelfth of the master clock, about 2.048 MHz from 24.576 MHz. When the processor begins a cycle, the block picks one of two 2-bit wait-state fields held in a control byte. The choice depends on the cycle's address, or on whether the cycle is idle. The block then holds the cycle busy for the number of base-clock enables that the chosen setting calls for.

The two slowest settings do not divide evenly into the base clock. For those settings the processor is held for 10 and 20 base clocks instead of 8 and 16. The timer side still follows the nominal divider of 2, 4, 8 or 16. The block reports that nominal count on a separate output, so the timers stay correct while the processor runs slow.

When a stall ends, the block raises a completion pulse in the final base-clock enable. It presents the timer-advance value in that same cycle.

Top module: `ws_divider`

## Requirements
- R1: After synchronous reset `cyc_busy` and `cyc_done` are 0, `tmr_adv` is 0, and both wait-state fields read as setting 0.
- R2: An idle cycle (`cyc_idle`=1) uses the internal field, bits 7:6 of the control byte, whatever its address.
- R3: A non-idle access to any address from 0x00F0 to 0x00FF inclusive uses the internal field.
- R4: A non-idle access at 0xFFC0 or above uses the internal field while `rom_en` is 1, and the external field (bits 5:4) while `rom_en` is 0.
- R5: Every other non-idle access uses the external field, bits 5:4. Bits 3:0 of the control byte have no effect on timing.
- R6: Settings 0, 1, 2 and 3 hold the cycle for 2, 4, 10 and 20 base-clock enables. The count starts with the first `base_ce` after the edge that accepts `cyc_start`. `cyc_done` is high exactly while the final counted `base_ce` is high, and `cyc_busy` is 0 from the following edge. Clock edges without `base_ce` do not count.
- R7: `tmr_adv` carries 2, 4, 8 or 16 for settings 0 to 3 during the `cyc_done` cycle, and is 0 at all other times.
- R8: The setting is chosen at the edge that accepts `cyc_start`. A control write in that same clock only takes effect from the next cycle.
- R9: `cyc_start` is ignored while `cyc_busy` is 1. It neither lengthens nor restarts the stall in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| base_ce | input | 1 | Base clock enable, one master clock in twelve |
| cyc_start | input | 1 | Processor begins a bus cycle (accepted when not busy) |
| cyc_idle | input | 1 | The starting cycle is an internal idle cycle |
| cyc_addr | input | 16 | Address of the starting cycle |
| rom_en | input | 1 | Boot ROM mapping enabled at the top of memory |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_data | input | 8 | Control byte: [7:6] internal setting, [5:4] external setting |
| cyc_busy | output | 1 | A cycle is being stalled |
| cyc_done | output | 1 | Final base clock of the stall |
| tmr_adv | output | 5 | Nominal timer advance, valid with `cyc_done`, else 0 |

## Verification
A control-register write and the acceptance of a new cycle can land on the same master-clock edge. The bench provokes this by raising `ctl_wr` with a slower setting in the same clock as `cyc_start`. It then counts base-clock enables up to `cyc_done`. It expects the old length on that cycle and the new length on the cycle after it. A second collision is a fresh `cyc_start` arriving in the middle of a stall. That case is judged by the original length still being kept and by `cyc_busy` falling right after the single `cyc_done`.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int WS_W   = 2;
    localparam int CNT_W  = 5;
    localparam int CTL_W  = 8;
    localparam int INT_LSB = 6;
    localparam int EXT_LSB = 4;

    typedef logic [WS_W-1:0]  ws_sel_t;
    typedef logic [CNT_W-1:0] ws_cnt_t;

    typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} ws_src_e;

    typedef struct packed {
        ws_sel_t int_ws;
        ws_sel_t ext_ws;
    } ws_ctl_t;

    // processor stall in base clocks; the two slow settings overrun
    function automatic ws_cnt_t stall_len(input ws_sel_t s);
        case (s)
            2'd0:    return ws_cnt_t'(2);
            2'd1:    return ws_cnt_t'(4);
            2'd2:    return ws_cnt_t'(10);
            default: return ws_cnt_t'(20);
        endcase
    endfunction

    // nominal divider seen by the timers
    function automatic ws_cnt_t timer_step(input ws_sel_t s);
        return ws_cnt_t'(2) << s;
    endfunction

endpackage

// File: rtl/ws_ctl_reg.sv
module ws_ctl_reg
    import ws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] data,
    output ws_ctl_t          ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{int_ws: '0, ext_ws: '0};
        end else if (wr) begin
            ctl.int_ws <= data[INT_LSB +: WS_W];
            ctl.ext_ws <= data[EXT_LSB +: WS_W];
        end
    end
endmodule

// File: rtl/ws_src_sel.sv
module ws_src_sel
    import ws_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] IO_LO  = 16'h00F0,
    parameter logic [15:0] IO_HI  = 16'h00FF,
    parameter logic [15:0] ROM_LO = 16'hFFC0
) (
    input  logic              idle,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    input  ws_ctl_t           ctl,
    output ws_sel_t           sel
);
    localparam logic [ADDR_W-1:0] IO_LO_A  = IO_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] IO_HI_A  = IO_HI[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ROM_LO_A = ROM_LO[ADDR_W-1:0];

    ws_src_e src;

    always_comb begin
        if (idle)
            src = SRC_INT;
        else if (addr >= IO_LO_A && addr <= IO_HI_A)
            src = SRC_INT;
        else if (addr >= ROM_LO_A && rom_en)
            src = SRC_INT;
        else
            src = SRC_EXT;
        sel = (src == SRC_INT) ? ctl.int_ws : ctl.ext_ws;
    end
endmodule

// File: rtl/ws_stall_ctr.sv
module ws_stall_ctr
    import ws_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    base_ce,
    input  logic    start,
    input  ws_sel_t sel,
    output logic    busy,
    output logic    done,
    output ws_cnt_t adv
);
    ws_cnt_t remain;
    ws_sel_t sel_q;

    assign done = busy && base_ce && (remain == ws_cnt_t'(1));
    assign adv  = done ? timer_step(sel_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            sel_q  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= stall_len(sel);
                sel_q  <= sel;
            end
        end else if (base_ce) begin
            remain <= remain - ws_cnt_t'(1);
            if (remain == ws_cnt_t'(1))
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/ws_divider.sv
module ws_divider
    import ws_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_ce,
    input  logic              cyc_start,
    input  logic              cyc_idle,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              rom_en,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_data,
    output logic              cyc_busy,
    output logic              cyc_done,
    output logic [CNT_W-1:0]  tmr_adv
);
    ws_ctl_t ctl;
    ws_sel_t sel;

    ws_ctl_reg u_reg (
        .clk (clk),
        .rst (rst),
        .wr  (ctl_wr),
        .data(ctl_data),
        .ctl (ctl)
    );

    ws_src_sel #(.ADDR_W(ADDR_W)) u_sel (
        .idle  (cyc_idle),
        .addr  (cyc_addr),
        .rom_en(rom_en),
        .ctl   (ctl),
        .sel   (sel)
    );

    ws_stall_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .base_ce(base_ce),
        .start  (cyc_start),
        .sel    (sel),
        .busy   (cyc_busy),
        .done   (cyc_done),
        .adv    (tmr_adv)
    );
endmodule

// File: rtl/ws_divider_chk.sv
module ws_divider_chk
    import ws_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             base_ce,
    input logic             cyc_start,
    input logic             cyc_busy,
    input logic             cyc_done,
    input logic [CNT_W-1:0] tmr_adv
);
    AST_DONE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> (base_ce && cyc_busy)); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_busy); // R6

    AST_ADV_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cyc_done |-> (tmr_adv == '0)); // R7

    AST_ADV_POW2: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> ($countones(tmr_adv) == 1 && !tmr_adv[0])); // R7

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cyc_busy && !cyc_done) |=> cyc_busy); // R9

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_busy) |-> $past(cyc_start)); // R9
endmodule

bind ws_divider ws_divider_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .base_ce  (base_ce),
    .cyc_start(cyc_start),
    .cyc_busy (cyc_busy),
    .cyc_done (cyc_done),
    .tmr_adv  (tmr_adv)
);

// File: tb/test_ws_divider.sv
module test_ws_divider;
    localparam int CLK_PERIOD = 10;
    localparam int BASE_DIV   = 12;
    localparam int NVEC       = 12;

    logic        clk = 1'b0;
    logic        rst, base_ce, cyc_start, cyc_idle, rom_en, ctl_wr;
    logic [15:0] cyc_addr;
    logic [7:0]  ctl_data;
    logic        cyc_busy, cyc_done;
    logic [4:0]  tmr_adv;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int phase  = 0;

    ws_divider i_ws_divider (
        .clk(clk), .rst(rst), .base_ce(base_ce), .cyc_start(cyc_start),
        .cyc_idle(cyc_idle), .cyc_addr(cyc_addr), .rom_en(rom_en),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data), .cyc_busy(cyc_busy),
        .cyc_done(cyc_done), .tmr_adv(tmr_adv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {ctl, idle, addr, rom_en, stall length, timer advance}
    localparam logic [35:0] VEC [NVEC] = '{
        {8'hC0, 1'b1, 16'h1234, 1'b0, 5'd20, 5'd16},  // R2 idle -> int=3
        {8'hC0, 1'b0, 16'h1234, 1'b0, 5'd2,  5'd2 },  // R5 ext=0
        {8'h30, 1'b0, 16'h00F0, 1'b0, 5'd2,  5'd2 },  // R3 low edge
        {8'h30, 1'b0, 16'h00FF, 1'b0, 5'd2,  5'd2 },  // R3 high edge
        {8'h30, 1'b0, 16'h00EF, 1'b0, 5'd20, 5'd16},  // R5 below window
        {8'h30, 1'b0, 16'h0100, 1'b0, 5'd20, 5'd16},  // R5 above window
        {8'h60, 1'b0, 16'hFFC0, 1'b1, 5'd4,  5'd4 },  // R4 rom on
        {8'h60, 1'b0, 16'hFFC0, 1'b0, 5'd10, 5'd8 },  // R4 rom off
        {8'h60, 1'b0, 16'hFFBF, 1'b1, 5'd10, 5'd8 },  // R5 just below rom
        {8'h9F, 1'b1, 16'h0000, 1'b0, 5'd10, 5'd8 },  // R2 low bits ignored
        {8'h9F, 1'b0, 16'hFFFF, 1'b1, 5'd10, 5'd8 },  // R4 top address
        {8'h9F, 1'b0, 16'h4000, 1'b1, 5'd4,  5'd4 }   // R5 ext=1
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_neg();
        @(negedge clk);
        base_ce = (phase == BASE_DIV - 1);
        phase   = (phase + 1) % BASE_DIV;
    endtask

    task automatic write_ctl(input logic [7:0] b);
        tick_neg();
        ctl_wr = 1'b1; ctl_data = b;
        tick_neg();
        ctl_wr = 1'b0;
    endtask

    // start a cycle; optional ctl write in the same clock; optional re-start at tick poke
    task automatic run(input logic idle, input logic [15:0] a, input logic rom,
                       input bit do_wr, input logic [7:0] wr_val, input int poke,
                       input int exp_len, input int exp_adv, input string req);
        int  cnt = 0;
        bit  seen = 0;
        tick_neg();
        cyc_start = 1'b1; cyc_idle = idle; cyc_addr = a; rom_en = rom;
        ctl_wr = do_wr; ctl_data = wr_val;
        for (int k = 0; k < 400 && !seen; k++) begin
            tick_neg();
            ctl_wr = 1'b0;
            cyc_start = (poke != 0 && cnt == poke) ? 1'b1 : 1'b0;
            cyc_idle  = 1'b1;
            #1;
            if (base_ce) cnt++;
            if (cyc_done) begin
                seen = 1;
                check(cnt == exp_len, {req, " stall length"}, cnt, exp_len);
                check(tmr_adv == 5'(exp_adv), {req, " R7 timer advance"}, tmr_adv, exp_adv);
            end
        end
        check(seen, {req, " done seen"}, seen, 1);
        tick_neg();
        cyc_start = 1'b0;
        #1;
        check(cyc_busy == 1'b0, {req, " R6 busy cleared"}, cyc_busy, 0);
        check(tmr_adv == 5'd0, "R7 advance idle", tmr_adv, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            checks++;
            $display("FAIL watchdog R6 actual=%0d expected<=200000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; base_ce = 1'b0; cyc_start = 1'b0; cyc_idle = 1'b0;
        cyc_addr = '0; rom_en = 1'b0; ctl_wr = 1'b0; ctl_data = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!cyc_busy && !cyc_done, "R1 reset flags", {cyc_busy, cyc_done}, 0);
        check(tmr_adv == 5'd0, "R1 reset advance", tmr_adv, 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: fields reset to setting 0 for both sources
        run(1'b1, 16'h0000, 1'b0, 0, 8'h00, 0, 2, 2, "R1 internal");
        run(1'b0, 16'h2000, 1'b0, 0, 8'h00, 0, 2, 2, "R1 external");

        for (int v = 0; v < NVEC; v++) begin
            write_ctl(VEC[v][35:28]);
            run(VEC[v][27], VEC[v][26:11], VEC[v][10], 0, 8'h00, 0,
                int'(VEC[v][9:5]), int'(VEC[v][4:0]), $sformatf("R6 vec%0d", v));
        end

        // R8: write in the start clock applies to the next cycle only
        write_ctl(8'h00);
        run(1'b0, 16'h3000, 1'b0, 1, 8'h30, 0, 2, 2, "R8 same-clock write");
        run(1'b0, 16'h3000, 1'b0, 0, 8'h00, 0, 20, 16, "R8 following cycle");

        // R9: start pulses during a stall are ignored
        write_ctl(8'h20);
        run(1'b0, 16'h3000, 1'b0, 0, 8'h00, 3, 10, 8, "R9 restart ignored");
        run(1'b0, 16'h3000, 1'b0, 0, 8'h00, 9, 10, 8, "R9 late restart ignored");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule